// File: doc/BRIEF.md
# Fixed-Point Dot-Product Filter Lane

This block is one filter lane inside a neural-network inference tile. On every accepted beat it multiplies sixteen signed 16-bit activations by sixteen signed 16-bit weights and reduces the sixteen products in an adder tree. It then adds that sum into a wide accumulator. A window is the run of beats that makes up one filter. It opens with a beat marked `in_first` and closes with a beat marked `in_last`. When the closing beat is accepted, the lane adds a bias and rescales the total into the next layer's fixed-point format with rounding and saturation. It then applies ReLU and presents one 16-bit activation.

Every value is a 16-bit two's-complement integer with a fraction count that is set per layer. Three static configuration inputs hold those counts: one for activations, one for weights, and one for the output, which is also the format of the bias. The accumulator therefore carries `act_frac + wgt_frac` fraction bits. Both streams use valid/ready. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. The lane lowers `in_ready` while a finished result is waiting with `out_ready` low. A presented result and its data stay unchanged until `out_ready` takes them.

Top module: `dl_lane`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: Each accepted beat adds the sum of its sixteen activation×weight products to the accumulator. A beat with `in_first` high discards whatever the accumulator held before and starts from that beat's sum.
- R3: The bias is in the output format. It is shifted left by `act_frac + wgt_frac - out_frac` and added to the accumulator. Configuration must satisfy `act_frac + wgt_frac >= out_frac`, and each count lies in 0..15.
- R4: The sum is arithmetically shifted right by `act_frac + wgt_frac - out_frac` with rounding half-up, meaning half of the dropped weight is added before the shift. With a shift of 0 the value passes through unchanged.
- R5: A rescaled value above 32767 is saturated to 32767.
- R6: ReLU: a rescaled value below zero is output as 0, so `out_act` is never negative while `out_valid` is high.
- R7: `out_valid` rises on the clock edge after the one that accepts an `in_last` beat.
- R8: While `out_valid` is high and `out_ready` is low, `out_act` and `out_valid` hold and `in_ready` is low.
- R9: Pairs driven with a zero weight leave the result unchanged whatever their activation. This is how a window that is not a multiple of sixteen pairs pads its final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_act_frac | input | 4 | Fraction bits of activations |
| cfg_wgt_frac | input | 4 | Fraction bits of weights |
| cfg_out_frac | input | 4 | Fraction bits of bias and output |
| cfg_bias | input | 16 | Bias in output format, sampled with the last beat |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Lane can accept a beat |
| in_first | input | 1 | Beat opens a window |
| in_last | input | 1 | Beat closes a window |
| in_act | input | 256 | Sixteen activations, lane i at bits [16i+15:16i] |
| in_wgt | input | 256 | Sixteen weights, lane i at bits [16i+15:16i] |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_act | output | 16 | Rescaled ReLU result |

## Verification
The assertions assume that the three fraction counts satisfy `act_frac + wgt_frac >= out_frac` whenever a beat is offered. They also assume that the configuration and bias stay steady across a window. The stimulus only picks format combinations that meet this rule, and it changes configuration only between windows. The sweeps vary the window length, the format triple, the bias and the operand ranges. Directed windows hit exact rounding halves, positive saturation, negative results, zero-weight padding and a held output under back-pressure.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int DL_LANES = 16;
  localparam int DL_DW    = 16;
  localparam int DL_FRW   = 4;
  localparam int DL_ACCW  = 40;
endpackage

// File: rtl/dl_mults.sv
module dl_mults #(
  parameter int LANES = 16,
  parameter int DW    = 16
) (
  input  logic [LANES*DW-1:0]   act,
  input  logic [LANES*DW-1:0]   wgt,
  output logic [LANES*2*DW-1:0] prod
);
  localparam int PW = 2 * DW;

  for (genvar i = 0; i < LANES; i++) begin : g_mul
    logic signed [PW-1:0] p;
    assign p = $signed(act[i*DW +: DW]) * $signed(wgt[i*DW +: DW]);
    assign prod[i*PW +: PW] = p;
  end
endmodule

// File: rtl/dl_addtree.sv
module dl_addtree #(
  parameter int N  = 16,
  parameter int IW = 32,
  parameter int OW = IW + $clog2(N)
) (
  input  logic [N*IW-1:0]       terms,
  output logic signed [OW-1:0]  sum
);
  // pairwise reduction, halving the live width each level (N a power of two)
  always_comb begin
    logic signed [OW-1:0] t [0:N-1];
    for (int i = 0; i < N; i++)
      t[i] = OW'($signed(terms[i*IW +: IW]));
    for (int w = N / 2; w >= 1; w = w / 2)
      for (int j = 0; j < w; j++)
        t[j] = t[2*j] + t[2*j+1];
    sum = t[0];
  end
endmodule

// File: rtl/dl_rescale.sv
module dl_rescale #(
  parameter int ACCW = 40,
  parameter int DW   = 16,
  parameter int FRW  = 4
) (
  input  logic signed [ACCW-1:0] acc,
  input  logic signed [DW-1:0]   bias,
  input  logic [FRW-1:0]         act_frac,
  input  logic [FRW-1:0]         wgt_frac,
  input  logic [FRW-1:0]         out_frac,
  output logic [DW-1:0]          result
);
  localparam int TW  = ACCW + 8;
  localparam int SHW = FRW + 2;
  localparam logic signed [TW-1:0] MAXV = TW'((1 <<< (DW - 1)) - 1);

  logic [SHW-1:0]        sh;
  logic signed [TW-1:0]  tot, rnd, shr;

  always_comb begin
    sh  = SHW'(act_frac) + SHW'(wgt_frac) - SHW'(out_frac);
    tot = TW'(acc) + (TW'(bias) <<< sh);
    rnd = (sh == '0) ? tot : tot + (TW'(1) <<< (sh - SHW'(1)));
    shr = rnd >>> sh;
    if (shr[TW-1])      result = '0;
    else if (shr > MAXV) result = MAXV[DW-1:0];
    else                result = shr[DW-1:0];
  end
endmodule

// File: rtl/dl_lane.sv
module dl_lane
  import dl_pkg::*;
#(
  parameter int LANES = DL_LANES,
  parameter int DW    = DL_DW,
  parameter int FRW   = DL_FRW,
  parameter int ACCW  = DL_ACCW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FRW-1:0]      cfg_act_frac,
  input  logic [FRW-1:0]      cfg_wgt_frac,
  input  logic [FRW-1:0]      cfg_out_frac,
  input  logic [DW-1:0]       cfg_bias,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_first,
  input  logic                in_last,
  input  logic [LANES*DW-1:0] in_act,
  input  logic [LANES*DW-1:0] in_wgt,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DW-1:0]       out_act
);
  localparam int PW = 2 * DW;
  localparam int SW = PW + $clog2(LANES);

  logic [LANES*PW-1:0]    prods;
  logic signed [SW-1:0]   beat_sum;
  logic signed [ACCW-1:0] acc_q, acc_base, acc_nx;
  logic [DW-1:0]          res;
  logic                   take;

  dl_mults #(.LANES(LANES), .DW(DW)) u_mul (
    .act(in_act), .wgt(in_wgt), .prod(prods));

  dl_addtree #(.N(LANES), .IW(PW), .OW(SW)) u_tree (
    .terms(prods), .sum(beat_sum));

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign acc_base = in_first ? '0 : acc_q;
  assign acc_nx   = acc_base + ACCW'(beat_sum);

  dl_rescale #(.ACCW(ACCW), .DW(DW), .FRW(FRW)) u_rs (
    .acc(acc_nx), .bias($signed(cfg_bias)),
    .act_frac(cfg_act_frac), .wgt_frac(cfg_wgt_frac), .out_frac(cfg_out_frac),
    .result(res));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_act   <= '0;
    end else begin
      if (take) acc_q <= acc_nx;
      if (take && in_last) begin
        out_valid <= 1'b1;
        out_act   <= res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R7
  valid_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> out_valid);

  // R7
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready && in_last));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_act)));

  // R6
  relu_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_act[DW-1]);

  // R3
  cfg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ({1'b0, cfg_act_frac} + {1'b0, cfg_wgt_frac} >= {1'b0, cfg_out_frac}));
endmodule

// File: tb/sim_dl_lane.sv
module sim_dl_lane;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] fa = 0, fw = 0, fo = 0;
  logic [15:0] bias = 0;
  logic in_valid = 0, in_first = 0, in_last = 0, out_ready = 1;
  logic in_ready, out_valid;
  logic [255:0] in_act = '0, in_wgt = '0;
  logic [15:0] out_act;

  int checks = 0;
  int fails = 0;
  int av [0:63];
  int wv [0:63];

  always #10 clk = ~clk;

  dl_lane u0 (
    .clk(clk), .rst_n(rst_n), .cfg_act_frac(fa), .cfg_wgt_frac(fw),
    .cfg_out_frac(fo), .cfg_bias(bias), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last), .in_act(in_act), .in_wgt(in_wgt),
    .out_valid(out_valid), .out_ready(out_ready), .out_act(out_act));

  task automatic check(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic longint ref_out(longint acc, int b, int a_f, int w_f, int o_f);
    int sh = a_f + w_f - o_f;
    longint t = acc + (longint'(b) <<< sh);
    if (sh > 0) t = (t + (64'sd1 <<< (sh - 1))) >>> sh;
    if (t > 32767) t = 32767;
    if (t < 0) t = 0;
    return t;
  endfunction

  // drives nb beats from av/wv, checks the result one edge after the last beat
  task automatic run_win(int nb, string req, bit hold);
    longint acc = 0;
    longint exp;
    for (int k = 0; k < nb * 16; k++) acc += longint'(av[k]) * longint'(wv[k]);
    exp = ref_out(acc, $signed(bias), fa, fw, fo);
    @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      in_valid = 1; in_first = (b == 0); in_last = (b == nb - 1);
      for (int i = 0; i < 16; i++) begin
        in_act[i*16 +: 16] = 16'(av[b*16+i]);
        in_wgt[i*16 +: 16] = 16'(wv[b*16+i]);
      end
      if (hold && b == nb - 1) out_ready = 0;
      @(negedge clk);
    end
    in_valid = 0; in_first = 0; in_last = 0;
    check({req, " valid"}, out_valid, 1);
    check({req, " data"}, out_act, exp);
    if (hold) begin
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        check("R8 held valid", out_valid, 1);
        check("R8 held data", out_act, exp);
        check("R8 in_ready low", in_ready, 0);
      end
      out_ready = 1;
      #1 check("R8 in_ready back", in_ready, 1);
      @(negedge clk);
      check("R8 drained", out_valid, 0);
    end
  endtask

  task automatic clear_vec();
    for (int k = 0; k < 64; k++) begin av[k] = 0; wv[k] = 0; end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int fa_l [4] = '{0, 5, 12, 14};
    int fo_l [4] = '{0, 4, 8, 12};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 out_valid", out_valid, 0);
    check("R1 in_ready", in_ready, 1);

    // R4: shift 1, exact halves round up
    fa = 1; fw = 1; fo = 1; bias = 0;
    clear_vec(); av[0] = 1; wv[0] = 1; run_win(1, "R4 half 1", 0);
    clear_vec(); av[0] = 3; wv[0] = 1; run_win(1, "R4 half 3", 0);
    clear_vec(); av[0] = -1; wv[0] = 1; run_win(1, "R4 half -1", 0);
    fa = 0; fw = 0; fo = 0;
    clear_vec(); av[5] = 123; wv[5] = 7; run_win(1, "R4 no shift", 0);

    // R3: bias only
    fa = 8; fw = 15; fo = 8; bias = 16'd100;
    clear_vec(); run_win(1, "R3 bias only", 0);
    bias = 16'(-5); av[0] = 256; wv[0] = 16384; run_win(1, "R3 bias plus", 0);

    // R5: positive saturation
    fa = 0; fw = 0; fo = 0; bias = 0;
    for (int k = 0; k < 64; k++) begin av[k] = 32767; wv[k] = 32767; end
    run_win(4, "R5 saturate", 0);

    // R6: negative result clamps to zero
    clear_vec(); av[0] = -100; wv[0] = 1; run_win(1, "R6 relu", 0);
    for (int k = 0; k < 64; k++) begin av[k] = -32768; wv[k] = 32767; end
    run_win(4, "R6 relu big", 0);

    // R9: 20 pairs over two beats, padding lanes carry zero weight
    fa = 12; fw = 15; fo = 8; bias = 16'd3;
    for (int k = 0; k < 32; k++) begin
      av[k] = int'($urandom_range(0, 8191)) - 4096;
      wv[k] = (k < 20) ? int'($urandom_range(0, 65535)) - 32768 : 0;
    end
    run_win(2, "R9 pad", 0);

    // R8: back-pressure on a two-beat window
    fa = 5; fw = 14; fo = 4; bias = 16'd50;
    for (int k = 0; k < 32; k++) begin
      av[k] = int'($urandom_range(0, 255)); wv[k] = int'($urandom_range(0, 4095));
    end
    run_win(2, "R8 window", 1);

    // R2 sweep: formats x window lengths x operand ranges
    for (int ia = 0; ia < 4; ia++)
      for (int iw = 14; iw <= 15; iw++)
        for (int io = 0; io < 4; io++)
          for (int nb = 1; nb <= 4; nb++)
            for (int rg = 0; rg < 2; rg++) begin
              fa = 4'(fa_l[ia]); fw = 4'(iw); fo = 4'(fo_l[io]);
              bias = 16'(int'($urandom_range(0, 2000)) - 1000);
              for (int k = 0; k < 64; k++) begin
                av[k] = (rg == 0) ? int'($urandom_range(0, 511)) - 256
                                  : int'($urandom_range(0, 65535)) - 32768;
                wv[k] = int'($urandom_range(0, 65535)) - 32768;
              end
              run_win(nb, "R2 sweep", 0);
            end
    summary();
  end
endmodule